// File: doc/BRIEF.md
# Display Start Line Scan Generator

This block walks a panel refresh one row at a time. For each row it produces the common (row) output index and the display-RAM line that the row shows. A start-line register decides which RAM line lands on the top row of the panel. Software can rewrite that register while the panel refreshes. This scrolls the image, or flips between screen buffers held in different RAM regions. A direction input decides whether the top row is driven on common output 0 or on the highest common output.

One frame is `LINES` scan steps (65 by default; 49 and 33 are the other sizes). Each step leaves the block as one beat on a valid/ready stream: `out_valid` stays high from the first clock after reset, and a beat is taken when `out_ready` is high. The row driver raises `out_ready` once per line strobe. If it holds `out_ready` low, the current beat stays on the outputs unchanged for as long as it is low. No beat is ever skipped or repeated.

A start-line write and a direction change are both held until the frame boundary, so every frame uses a single offset and a single direction.

Top module: `scanline_gen`

## Requirements
- R1: While `rst_n` is low, `out_valid` and `frame_first` are 0. After reset the start line is 0 and the direction is normal, so the first beat carries `ram_line`=0, `com_idx`=0 and `frame_first`=1.
- R2: On scan step k of a frame (k = 0 … LINES-1), `ram_line` equals (start + k) mod LINES, where start is the frame's start line.
- R3: `com_idx` equals k when the frame's direction is normal (0), and equals LINES-1-k when it is reversed (1).
- R4: A start-line write (`start_wr`=1) takes effect only at the next frame boundary. A write in the same cycle as the frame's last accepted beat applies to the very next frame. When several writes fall in one frame, the last one wins.
- R5: A frame is exactly LINES accepted beats. `frame_first` is 1 only on the beat for step 0.
- R6: `ram_page` = `ram_line` / 8 and `ram_bit` = `ram_line` % 8. For LINES=65, line 64 gives page 8, bit 0.
- R7: While `out_valid`=1 and `out_ready`=0, `com_idx`, `ram_line`, `ram_page`, `ram_bit` and `frame_first` hold their values.
- R8: A start-line write whose value is LINES or larger is ignored. The start line stays as it was.
- R9: `com_reverse` is sampled at each frame boundary (the last accepted beat) and applies to the whole next frame.
- R10: Once high after reset, `out_valid` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_wr | input | 1 | Start-line write strobe |
| start_line | input | LW | Start-line value to write |
| com_reverse | input | 1 | 1 = top line on the highest common output |
| out_valid | output | 1 | Scan beat available |
| out_ready | input | 1 | Row driver accepts the beat (line strobe) |
| com_idx | output | LW | Common output index for this beat |
| ram_line | output | LW | Display RAM line for this beat |
| ram_page | output | LW-3 | RAM page (line / 8) |
| ram_bit | output | 3 | Bit within page (line % 8) |
| frame_first | output | 1 | Beat is step 0 of a frame |

## Verification
A wrong step counter or a wrong applied offset shows on `ram_line` and `com_idx` on the very next accepted beat, since both come straight from that state. A bad wrap appears when the first out-of-range line reaches the outputs. A start-line or direction value applied too early shows as a jump part-way through a frame. A value applied too late leaves the old offset on the first beat of the next frame. The reference model predicts every beat, and comparing it each cycle catches any of these within one clock.

// File: rtl/scanline_pkg.sv
package scanline_pkg;
  // (a + b) mod n for a, b already below n
  function automatic int wrap_add(input int a, input int b, input int n);
    int s;
    s = a + b;
    return (s >= n) ? s - n : s;
  endfunction
endpackage

// File: rtl/scan_stepper.sv
module scan_stepper #(
  parameter int LINES = 65,
  parameter int LW    = $clog2(LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ready,
  output logic          valid,
  output logic [LW-1:0] step,
  output logic          boundary
);
  localparam logic [LW-1:0] LAST = LW'(LINES - 1);

  logic adv;
  assign adv      = valid & ready;
  assign boundary = adv & (step == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      step  <= '0;
    end else begin
      valid <= 1'b1;
      if (adv) step <= (step == LAST) ? '0 : step + 1'b1;
    end
  end
endmodule

// File: rtl/frame_regs.sv
module frame_regs #(
  parameter int LINES = 65,
  parameter int LW    = $clog2(LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [LW-1:0] wr_val,
  input  logic          rev_in,
  input  logic          boundary,
  output logic [LW-1:0] act_start,
  output logic          act_rev
);
  logic [LW-1:0] pend_start;
  logic          wr_ok;

  assign wr_ok = wr && (int'(wr_val) < LINES);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_start <= '0;
      act_start  <= '0;
      act_rev    <= 1'b0;
    end else begin
      if (wr_ok) pend_start <= wr_val;
      if (boundary) begin
        act_start <= wr_ok ? wr_val : pend_start;
        act_rev   <= rev_in;
      end
    end
  end
endmodule

// File: rtl/line_mapper.sv
module line_mapper
  import scanline_pkg::*;
#(
  parameter int LINES = 65,
  parameter int LW    = $clog2(LINES)
) (
  input  logic [LW-1:0] step,
  input  logic [LW-1:0] start,
  input  logic          rev,
  output logic [LW-1:0] com,
  output logic [LW-1:0] line,
  output logic [LW-4:0] page,
  output logic [2:0]    bitsel
);
  always_comb begin
    line = LW'(wrap_add(int'(start), int'(step), LINES));
    com  = rev ? LW'(LINES - 1 - int'(step)) : step;
  end

  assign page   = line[LW-1:3];
  assign bitsel = line[2:0];
endmodule

// File: rtl/scanline_gen.sv
module scanline_gen #(
  parameter int LINES = 65,
  parameter int LW    = $clog2(LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_wr,
  input  logic [LW-1:0] start_line,
  input  logic          com_reverse,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [LW-1:0] com_idx,
  output logic [LW-1:0] ram_line,
  output logic [LW-4:0] ram_page,
  output logic [2:0]    ram_bit,
  output logic          frame_first
);
  logic [LW-1:0] step;
  logic [LW-1:0] act_start;
  logic          act_rev;
  logic          boundary;

  scan_stepper #(.LINES(LINES), .LW(LW)) u_step (
    .clk(clk), .rst_n(rst_n), .ready(out_ready),
    .valid(out_valid), .step(step), .boundary(boundary)
  );

  frame_regs #(.LINES(LINES), .LW(LW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(start_wr), .wr_val(start_line),
    .rev_in(com_reverse), .boundary(boundary),
    .act_start(act_start), .act_rev(act_rev)
  );

  line_mapper #(.LINES(LINES), .LW(LW)) u_map (
    .step(step), .start(act_start), .rev(act_rev),
    .com(com_idx), .line(ram_line), .page(ram_page), .bitsel(ram_bit)
  );

  assign frame_first = out_valid && (step == '0);
endmodule

// File: rtl/scanline_gen_chk.sv
module scanline_gen_chk #(
  parameter int LINES = 65,
  parameter int LW    = $clog2(LINES)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          out_valid,
  input logic          out_ready,
  input logic [LW-1:0] com_idx,
  input logic [LW-1:0] ram_line,
  input logic          frame_first
);
  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> $stable(ram_line) && $stable(com_idx) && $stable(frame_first)); // R7
  AST_LINE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> int'(ram_line) < LINES); // R2
  AST_LINE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> frame_first ||
      int'(ram_line) == (int'($past(ram_line)) + 1) % LINES); // R2
  AST_COM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> frame_first ||
      int'(com_idx) == int'($past(com_idx)) + 1 || int'(com_idx) == int'($past(com_idx)) - 1); // R3
  AST_FRAME_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_first |-> (int'(com_idx) == 0 || int'(com_idx) == LINES - 1)); // R5
  AST_VALID_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> out_valid); // R10
endmodule

bind scanline_gen scanline_gen_chk #(.LINES(LINES), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .com_idx(com_idx), .ram_line(ram_line), .frame_first(frame_first)
);

// File: tb/sim_scanline_gen.sv
`timescale 1ns/1ps
module sim_scanline_gen;
  localparam int N  = 65;
  localparam int LW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_wr = 1'b0;
  logic [LW-1:0] start_line = '0;
  logic          com_reverse = 1'b0;
  logic          out_ready = 1'b0;
  logic          out_valid, frame_first;
  logic [LW-1:0] com_idx, ram_line;
  logic [LW-4:0] ram_page;
  logic [2:0]    ram_bit;

  int errs = 0, checks = 0, cyc = 0;
  int m_k = 0, m_act = 0, m_pend = 0, m_rev = 0, m_valid = 0;
  logic prev_stall = 1'b0;
  int prev_line = 0, prev_com = 0;
  logic saw64 = 1'b0;

  always #10 clk = ~clk;

  scanline_gen #(.LINES(N)) u0 (
    .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .start_line(start_line),
    .com_reverse(com_reverse), .out_valid(out_valid), .out_ready(out_ready),
    .com_idx(com_idx), .ram_line(ram_line), .ram_page(ram_page),
    .ram_bit(ram_bit), .frame_first(frame_first)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // reference model: advances on each clock edge
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_k = 0; m_act = 0; m_pend = 0; m_rev = 0; m_valid = 0;
    end else begin
      if (m_valid == 1 && out_ready) begin
        if (m_k == N - 1) begin
          m_k = 0;
          m_act = (start_wr && int'(start_line) < N) ? int'(start_line) : m_pend;
          m_rev = int'(com_reverse);
        end else m_k++;
      end
      if (start_wr && int'(start_line) < N) m_pend = int'(start_line);
      m_valid = 1;
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    int el, ec;
    el = (m_act + m_k) % N;
    ec = (m_rev == 1) ? N - 1 - m_k : m_k;
    chk(int'(out_valid) == m_valid, "R1,R10 valid", int'(out_valid), m_valid);
    chk(int'(frame_first) == int'(m_valid == 1 && m_k == 0), "R5 frame_first",
        int'(frame_first), int'(m_valid == 1 && m_k == 0));
    chk(int'(ram_line) == el, "R2,R4,R8 ram_line", int'(ram_line), el);
    chk(int'(com_idx) == ec, "R3,R9 com_idx", int'(com_idx), ec);
    chk(int'(ram_page) == el / 8 && int'(ram_bit) == el % 8, "R6 page/bit",
        int'(ram_page) * 8 + int'(ram_bit), el);
    if (prev_stall)
      chk(int'(ram_line) == prev_line && int'(com_idx) == prev_com, "R7 hold",
          int'(ram_line), prev_line);
    if (int'(ram_line) == 64 && out_valid) begin
      saw64 = 1'b1;
      chk(int'(ram_page) == 8 && int'(ram_bit) == 0, "R6 line64", int'(ram_page), 8);
    end
    prev_stall = out_valid && !out_ready && rst_n;
    prev_line  = int'(ram_line);
    prev_com   = int'(com_idx);
  end

  task automatic step_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_start(input int v);
    @(negedge clk);
    start_wr = 1'b1; start_line = LW'(v);
    @(negedge clk);
    start_wr = 1'b0;
  endtask

  // watchdog
  initial begin
    #3000000;
    errs++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    step_n(3);
    chk(out_valid == 1'b0 && frame_first == 1'b0, "R1 reset", int'(out_valid), 0);
    rst_n = 1'b1;
    step_n(1);
    chk(out_valid && frame_first && ram_line == 0 && com_idx == 0, "R1 first beat",
        int'(ram_line), 0);
    out_ready = 1'b1;
    step_n(2 * N + 3);
    // mid-frame write must wait for boundary (R4), later write wins
    write_start(10);
    write_start(20);
    step_n(2 * N);
    // invalid start values ignored (R8)
    write_start(70);
    write_start(127);
    com_reverse = 1'b1; // R9: applies from next frame
    step_n(2 * N);
    // write in the cycle of the final beat (R4)
    while (!(m_k == N - 2)) @(negedge clk);
    @(negedge clk);
    start_wr = 1'b1; start_line = LW'(64);
    @(negedge clk);
    start_wr = 1'b0;
    chk(int'(ram_line) == 64 && frame_first, "R4 boundary write", int'(ram_line), 64);
    step_n(N + 5);
    // back-pressure with random stalls, writes and direction flips (R7)
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      out_ready = ($urandom % 3) != 0;
      start_wr = ($urandom % 40) == 0;
      start_line = LW'($urandom % 128);
      if (($urandom % 200) == 0) com_reverse = ~com_reverse;
    end
    @(negedge clk);
    start_wr = 1'b0; out_ready = 1'b1;
    step_n(2 * N);
    chk(saw64, "R6 line64 seen", int'(saw64), 1);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule